// File: doc/BRIEF.md
# Filtered Edge Time-Stamp Unit

This block time-stamps level changes on noisy external inputs. Each channel takes a raw pin, brings it into the clock domain through a two-flop synchroniser and passes it through a noise filter. The filter samples the pin on a slow strobe and accepts a new level only after that level has been seen on several strobe samples in a row. When the filtered level changes in the direction a channel is configured for, the channel copies the value of an external 16-bit free-running count into its capture register. It also raises a sticky flag and gives a one-cycle interrupt pulse. Two readings taken this way give an event interval or a pulse width.

For each channel, the filter length (three or four samples) and the strobe interval can be chosen separately, and the filter can be switched off. When it is off, the synchronised level goes straight to the edge detector. The count source and any register access interface sit outside the block. Software reads `cap_val`, `cap_flag` and `cap_ovr` and acknowledges a capture with `flag_clr`.

Top module: `cap_filter_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every channel reads `cap_val`=0, `cap_flag`=0, `cap_ovr`=0 and `cap_irq`=0. The filtered level starts at 0.
- R2: With the filter off (`cfg_filt_en`=0), a pin change that the first rising edge samples is captured on the fourth rising edge, counting that first edge as one. The edge goes through two synchroniser flops, one level register and the edge compare.
- R3: A shared prescaler starts at 0 after reset and counts up by one every cycle, with 3 bits. Rate code n (`cfg_rate` field, 2 bits per channel, channel c at bits [2c+1:2c]) gives a sample strobe in the cycles where the low n prescaler bits are all ones. So code 0 samples every cycle, 1 every 2nd, 2 every 4th and 3 every 8th.
- R4: With the filter on, the filtered level changes only on a strobe. It changes only when the newest L strobe samples of the synchronised pin are equal and differ from the current level. L is 3 when `cfg_len4`=0 and 4 when it is 1. A shorter pulse never reaches the edge detector.
- R5: The edge code (`cfg_edge`, 2 bits per channel, channel c at [2c+1:2c]) sets which changes of the filtered level capture. 0 captures rising changes, 1 falling, 2 both, and 3 none.
- R6: A capture loads `count_in`, as sampled on the detecting clock edge, into that channel's `cap_val`. In the same cycle it sets `cap_flag` and pulses `cap_irq` high for one cycle. `cap_val` does not change in any other cycle.
- R7: `cap_flag` stays set until a `flag_clr` strobe for that channel. The strobe clears both `cap_flag` and `cap_ovr` on the next edge. If a capture happens on the same edge as the clear, the flag stays set and the overrun bit is not set.
- R8: A capture while `cap_flag` is set and not being cleared sets `cap_ovr`, and `cap_val` takes the newer value.
- R9: The channels are independent. Activity or configuration on one channel never changes another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | NCH | Raw asynchronous capture inputs, one bit per channel |
| count_in | input | TW | Free-running count to be time-stamped |
| cfg_len4 | input | NCH | Filter length per channel: 0 = three samples, 1 = four |
| cfg_rate | input | 2*NCH | Strobe interval code per channel |
| cfg_filt_en | input | NCH | Filter enable per channel |
| cfg_edge | input | 2*NCH | Capture edge code per channel |
| flag_clr | input | NCH | Write-one-to-clear strobe for flag and overrun |
| cap_val | output | NCH*TW | Capture registers, channel c at [TW*c +: TW] |
| cap_flag | output | NCH | Sticky capture flags |
| cap_ovr | output | NCH | Overrun bits |
| cap_irq | output | NCH | One-cycle capture interrupt pulses |

## Verification
A wrong prescaler phase or a miscounted filter history shows up as a capture that lands a strobe period early or late. It can also show up as a glitch that should have been rejected but raises `cap_flag`. Either way, `cap_val` carries a count value different from the expected one within one to eight strobe periods of the pin change. A broken synchroniser or edge register shifts every bypass capture by one count, which the first directed capture exposes. Errors in flag or overrun state appear the cycle after the capture or clear that exposes them. The stimulus mixes directed glitches, overruns and clears with random pin activity and random configuration changes on both channels.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } edge_mode_t;

  localparam int unsigned RATE_W = 2;

  function automatic logic edge_hit(edge_mode_t mode, logic now_lvl, logic old_lvl);
    logic rise, fall;
    rise = now_lvl & ~old_lvl;
    fall = ~now_lvl & old_lvl;
    case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cap_prescale.sv
module cap_prescale #(
  parameter int unsigned RATE_W = 2,
  localparam int unsigned NRATE = 2 ** RATE_W,
  localparam int unsigned CW = NRATE - 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [NRATE-1:0] strobe
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign strobe[0] = 1'b1;
  for (genvar n = 1; n < NRATE; n++) begin : g_stb
    assign strobe[n] = &cnt[n-1:0];
  end
endmodule

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int unsigned SHORT_LEN = 3,
  parameter int unsigned LONG_LEN  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic strobe,
  input  logic en,
  input  logic len4,
  output logic lvl
);
  logic [LONG_LEN-2:0] hist;
  logic [LONG_LEN-1:0] window;
  logic hi_s, lo_s, hi_l, lo_l, take_hi, take_lo;

  assign window = {hist, sync_in};
  assign hi_s = &window[SHORT_LEN-1:0];
  assign lo_s = ~|window[SHORT_LEN-1:0];
  assign hi_l = &window;
  assign lo_l = ~|window;

  always_comb begin
    take_hi = len4 ? hi_l : hi_s;
    take_lo = len4 ? lo_l : lo_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      lvl  <= 1'b0;
    end else begin
      if (strobe) hist <= window[LONG_LEN-2:0];
      if (!en)                      lvl <= sync_in;
      else if (strobe && take_hi)   lvl <= 1'b1;
      else if (strobe && take_lo)   lvl <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl,
  input  edge_mode_t    mode,
  input  logic          clr,
  input  logic [TW-1:0] count,
  output logic [TW-1:0] val,
  output logic          flag,
  output logic          ovr,
  output logic          irq
);
  logic prev, hit;

  assign hit = edge_hit(mode, lvl, prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      val  <= '0;
      flag <= 1'b0;
      ovr  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      prev <= lvl;
      irq  <= hit;
      if (hit) val <= count;
      flag <= hit | (flag & ~clr);
      ovr  <= (hit & flag & ~clr) | (ovr & ~clr);
    end
  end
endmodule

// File: rtl/cap_filter_unit.sv
module cap_filter_unit
  import cap_pkg::*;
#(
  parameter int unsigned NCH       = 2,
  parameter int unsigned TW        = 16,
  parameter int unsigned SYNC_LEN  = 2,
  parameter int unsigned SHORT_LEN = 3,
  parameter int unsigned LONG_LEN  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        pin_raw,
  input  logic [TW-1:0]         count_in,
  input  logic [NCH-1:0]        cfg_len4,
  input  logic [2*NCH-1:0]      cfg_rate,
  input  logic [NCH-1:0]        cfg_filt_en,
  input  logic [2*NCH-1:0]      cfg_edge,
  input  logic [NCH-1:0]        flag_clr,
  output logic [NCH*TW-1:0]     cap_val,
  output logic [NCH-1:0]        cap_flag,
  output logic [NCH-1:0]        cap_ovr,
  output logic [NCH-1:0]        cap_irq
);
  localparam int unsigned NRATE = 2 ** RATE_W;

  logic [NRATE-1:0] stb_bus;
  logic [NCH-1:0]   sync_lvl;
  logic [NCH-1:0]   stb_sel;
  logic [NCH-1:0]   filt_lvl;

  cap_prescale #(.RATE_W(RATE_W)) i_pre (
    .clk(clk), .rst(rst), .strobe(stb_bus)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [RATE_W-1:0] rate;
    assign rate = cfg_rate[RATE_W*c +: RATE_W];
    assign stb_sel[c] = stb_bus[rate];

    cap_sync #(.STAGES(SYNC_LEN)) i_sync (
      .clk(clk), .rst(rst), .d(pin_raw[c]), .q(sync_lvl[c])
    );

    cap_filter #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) i_filt (
      .clk(clk), .rst(rst), .sync_in(sync_lvl[c]), .strobe(stb_sel[c]),
      .en(cfg_filt_en[c]), .len4(cfg_len4[c]), .lvl(filt_lvl[c])
    );

    cap_channel #(.TW(TW)) i_chan (
      .clk(clk), .rst(rst), .lvl(filt_lvl[c]),
      .mode(edge_mode_t'(cfg_edge[2*c +: 2])), .clr(flag_clr[c]),
      .count(count_in), .val(cap_val[TW*c +: TW]),
      .flag(cap_flag[c]), .ovr(cap_ovr[c]), .irq(cap_irq[c])
    );
  end
endmodule

// File: rtl/cap_filter_chk.sv
module cap_filter_chk #(
  parameter int unsigned NCH = 2,
  parameter int unsigned TW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH*TW-1:0] cap_val,
  input logic [NCH-1:0]    cap_flag,
  input logic [NCH-1:0]    cap_ovr,
  input logic [NCH-1:0]    cap_irq,
  input logic [NCH-1:0]    flag_clr,
  input logic [NCH-1:0]    filt_en,
  input logic [NCH-1:0]    filt_lvl,
  input logic [NCH-1:0]    stb_sel
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r6_irq_sets_flag: assert property (@(posedge clk) disable iff (rst)
      cap_irq[i] |-> cap_flag[i]);
    a_r6_val_holds: assert property (@(posedge clk) disable iff (rst)
      !cap_irq[i] |-> $stable(cap_val[TW*i +: TW]));
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (cap_flag[i] && !flag_clr[i]) |=> cap_flag[i]);
    a_r8_ovr_needs_flag: assert property (@(posedge clk) disable iff (rst)
      cap_ovr[i] |-> cap_flag[i]);
    a_r4_filter_on_strobe: assert property (@(posedge clk) disable iff (rst)
      ($past(filt_en[i]) && !$past(stb_sel[i])) |-> $stable(filt_lvl[i]));
  end
endmodule

bind cap_filter_unit cap_filter_chk #(.NCH(NCH), .TW(TW)) i_chk (
  .clk(clk), .rst(rst), .cap_val(cap_val), .cap_flag(cap_flag),
  .cap_ovr(cap_ovr), .cap_irq(cap_irq), .flag_clr(flag_clr),
  .filt_en(cfg_filt_en), .filt_lvl(filt_lvl), .stb_sel(stb_sel)
);

// File: tb/test_cap_filter_unit.sv
module test_cap_filter_unit;
  localparam int NCH = 2;
  localparam int TW  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [NCH-1:0]    pin_raw;
  logic [TW-1:0]     count_in;
  logic [NCH-1:0]    cfg_len4, cfg_filt_en, flag_clr;
  logic [2*NCH-1:0]  cfg_rate, cfg_edge;
  logic [NCH*TW-1:0] cap_val;
  logic [NCH-1:0]    cap_flag, cap_ovr, cap_irq;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cap_filter_unit i_cap_filter_unit (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .count_in(count_in),
    .cfg_len4(cfg_len4), .cfg_rate(cfg_rate), .cfg_filt_en(cfg_filt_en),
    .cfg_edge(cfg_edge), .flag_clr(flag_clr), .cap_val(cap_val),
    .cap_flag(cap_flag), .cap_ovr(cap_ovr), .cap_irq(cap_irq)
  );

  always @(posedge clk) begin
    if (rst) count_in <= 16'h1000;
    else     count_in <= count_in + 16'd1;
  end

  // Reference model built from the requirements
  logic [2:0]    m_pre;
  logic [NCH-1:0] m_s1, m_s2, m_lvl, m_prev, m_flag, m_ovr, m_irq;
  logic [2:0]    m_hist [NCH];
  logic [TW-1:0] m_val  [NCH];

  function automatic bit f_strobe(logic [2:0] pre, logic [1:0] rate);
    case (rate)
      2'd0: return 1'b1;
      2'd1: return pre[0];
      2'd2: return &pre[1:0];
      default: return &pre;
    endcase
  endfunction

  function automatic bit f_hit(logic [1:0] mode, logic now_l, logic old_l);
    case (mode)
      2'd0: return now_l & ~old_l;
      2'd1: return ~now_l & old_l;
      2'd2: return now_l ^ old_l;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre <= '0; m_s1 <= '0; m_s2 <= '0; m_lvl <= '0; m_prev <= '0;
      m_flag <= '0; m_ovr <= '0; m_irq <= '0;
      for (int c = 0; c < NCH; c++) begin m_hist[c] <= '0; m_val[c] <= '0; end
    end else begin
      m_pre <= m_pre + 3'd1;
      m_s1  <= pin_raw;
      m_s2  <= m_s1;
      for (int c = 0; c < NCH; c++) begin
        bit stb, h;
        logic [3:0] win;
        int need;
        stb  = f_strobe(m_pre, cfg_rate[2*c +: 2]);
        win  = {m_hist[c], m_s2[c]};
        need = cfg_len4[c] ? 4 : 3;
        if (stb) m_hist[c] <= win[2:0];
        if (!cfg_filt_en[c]) m_lvl[c] <= m_s2[c];
        else if (stb) begin
          if (need == 4 ? (win == 4'hF) : (win[2:0] == 3'h7)) m_lvl[c] <= 1'b1;
          else if (need == 4 ? (win == 4'h0) : (win[2:0] == 3'h0)) m_lvl[c] <= 1'b0;
        end
        h = f_hit(cfg_edge[2*c +: 2], m_lvl[c], m_prev[c]);
        m_prev[c] <= m_lvl[c];
        m_irq[c]  <= h;
        if (h) m_val[c] <= count_in;
        m_flag[c] <= h | (m_flag[c] & ~flag_clr[c]);
        m_ovr[c]  <= (h & m_flag[c] & ~flag_clr[c]) | (m_ovr[c] & ~flag_clr[c]);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      for (int c = 0; c < NCH; c++) begin
        chk("R6 cap_val vs model", cap_val[TW*c +: TW], m_val[c]);
        chk("R7 cap_flag vs model", cap_flag[c], m_flag[c]);
        chk("R8 cap_ovr vs model", cap_ovr[c], m_ovr[c]);
        chk("R6 cap_irq vs model", cap_irq[c], m_irq[c]);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    logic [TW-1:0] c0;
    int unsigned seed_junk;
    seed_junk = $urandom(32'd20240611);
    rst = 1'b1; pin_raw = '0; cfg_len4 = '0; cfg_rate = '0; cfg_filt_en = '0;
    cfg_edge = '0; flag_clr = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset cap_val", cap_val, '0);
    chk("R1 reset cap_flag", cap_flag, '0);
    chk("R1 reset cap_ovr", cap_ovr, '0);
    chk("R1 reset cap_irq", cap_irq, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post-reset cap_flag", cap_flag, '0);
    cmp_on = 1'b1;

    // R2: bypass latency, rising edge on channel 0
    repeat (3) @(negedge clk);
    pin_raw[0] = 1'b1;
    c0 = count_in;
    repeat (3) @(negedge clk);
    chk("R2 no capture before fourth edge", cap_flag[0], 1'b0);
    @(negedge clk);
    chk("R2 bypass capture value", cap_val[TW-1:0], c0 + 16'd3);
    chk("R6 irq with capture", cap_irq[0], 1'b1);
    @(negedge clk);
    chk("R6 irq single cycle", cap_irq[0], 1'b0);
    chk("R9 other channel untouched", cap_flag[1], 1'b0);

    // R8: second rising capture without clear
    pin_raw[0] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 falling ignored in rise mode", cap_ovr[0], 1'b0);
    pin_raw[0] = 1'b1;
    c0 = count_in;
    repeat (4) @(negedge clk);
    chk("R8 overrun set", cap_ovr[0], 1'b1);
    chk("R8 newer value kept", cap_val[TW-1:0], c0 + 16'd3);

    // R7: clear
    flag_clr[0] = 1'b1;
    @(negedge clk);
    flag_clr[0] = 1'b0;
    chk("R7 flag cleared", cap_flag[0], 1'b0);
    chk("R7 overrun cleared", cap_ovr[0], 1'b0);

    // R4: filter on, 3 samples, every cycle, both edges; 2-cycle glitch rejected
    cfg_filt_en[0] = 1'b1; cfg_edge[1:0] = 2'd2;
    repeat (6) @(negedge clk);
    pin_raw[0] = 1'b0;
    repeat (2) @(negedge clk);
    pin_raw[0] = 1'b1;
    repeat (12) @(negedge clk);
    chk("R4 short glitch rejected", cap_flag[0], 1'b0);
    pin_raw[0] = 1'b0;
    repeat (3) @(negedge clk);
    pin_raw[0] = 1'b1;
    repeat (12) @(negedge clk);
    chk("R4 three-sample pulse accepted", cap_flag[0], 1'b1);
    chk("R5 both edges give overrun", cap_ovr[0], 1'b1);

    // R4: length 4 rejects a 3-cycle pulse
    flag_clr[0] = 1'b1; cfg_len4[0] = 1'b1;
    @(negedge clk);
    flag_clr[0] = 1'b0;
    pin_raw[0] = 1'b0;
    repeat (3) @(negedge clk);
    pin_raw[0] = 1'b1;
    repeat (12) @(negedge clk);
    chk("R4 four-sample filter rejects 3", cap_flag[0], 1'b0);

    // R3: divide-by-8 strobe rejects a 10-cycle pulse at length 3
    cfg_len4[0] = 1'b0; cfg_rate[1:0] = 2'd3;
    repeat (10) @(negedge clk);
    pin_raw[0] = 1'b0;
    repeat (10) @(negedge clk);
    pin_raw[0] = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 slow strobe rejects 10-cycle pulse", cap_flag[0], 1'b0);

    // R5: edge code none
    cfg_edge[3:2] = 2'd3;
    pin_raw[1] = 1'b1;
    repeat (8) @(negedge clk);
    pin_raw[1] = 1'b0;
    repeat (8) @(negedge clk);
    chk("R5 edge none no capture", cap_flag[1], 1'b0);

    // Random phase, both channels, model compare every cycle
    for (int blk = 0; blk < 30; blk++) begin
      cfg_len4    = NCH'($urandom);
      cfg_filt_en = NCH'($urandom);
      cfg_rate    = (2*NCH)'($urandom);
      cfg_edge    = (2*NCH)'($urandom);
      for (int cyc = 0; cyc < 300; cyc++) begin
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
          if ($urandom_range(0, 5) == 0) pin_raw[c] = ~pin_raw[c];
          flag_clr[c] = ($urandom_range(0, 40) == 0);
        end
      end
    end
    flag_clr = '0;
    repeat (5) @(negedge clk);
    cmp_on = 1'b0;
    summary();
  end
endmodule